// File: doc/BRIEF.md
# Eight-Character Line Buffer

This block holds one line of eight 8-bit characters for a small text display and exposes them to a bus master as an eight-byte register window. Reads and writes carry 1, 2, 4 or 8 bytes. Each access may start at any byte offset inside the window. Byte positions wrap around modulo eight, so a wide access that starts near the end of the window continues at position 0.

Every accepted write pulses a refresh strobe and presents the whole line on a parallel output, so a downstream display driver can redraw it. Positions that were never written hold zero.

When the display link first comes up after reset, the block emits a single blank character once. It does not repeat that character until the next reset.

Top module: `char_line_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_o` is all zero and `refresh_o`, `rsp_valid_o` and `blank_valid_o` are low.
- R2: `req_ready_o` is high out of reset, so each request is accepted in the cycle it is presented. `req_size_i` gives the byte count, and the legal values are 1, 2, 4 and 8.
- R3: On a legal write, byte i of `req_wdata_i` (bits [8i+7:8i]) is stored at position (`req_offset_i` + i) mod 8. Position p of the line appears on `line_o` bits [8p+7:8p].
- R4: On a read, `rsp_valid_o` is high for one cycle in the cycle after acceptance. In that cycle, lane i of `rsp_rdata_o` (bits [8i+7:8i]) holds position (`req_offset_i` + i) mod 8.
- R5: Read lanes at index `req_size_i` and above return zero.
- R6: `refresh_o` is high exactly in the cycle after a legal write is accepted, and low in every other cycle. In that cycle `line_o` already shows the updated line.
- R7: A write with an illegal size leaves `line_o` unchanged and raises no refresh.
- R8: A read with an illegal size still returns a response, and all of its data is zero.
- R9: The first cycle after reset in which `link_up_i` is high causes `blank_valid_o` to be high for exactly the next cycle, with `blank_char_o` = 8'h20. Later link activity never raises `blank_valid_o` again before a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 3 | Starting byte position |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data, little-endian lanes |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data, little-endian lanes |
| link_up_i | input | 1 | Display link is up |
| blank_valid_o | output | 1 | One-time blank character strobe |
| blank_char_o | output | 8 | Blank character code |
| refresh_o | output | 1 | Line refresh strobe |
| line_o | output | 64 | Full line, position p at bits [8p+7:8p] |

## Verification
Writes and reads run at every offset with every legal size. The wrapping cases (offset 6 with size 4, offset 5 with size 8) separate modulo-eight indexing from clamped or linear indexing. Reads that follow overlapping writes separate lane order from position order, and show whether zero-masking is applied per lane or per word. Illegal sizes (0, 3, 7, 15) confirm that writes are dropped and that reads return zero. Toggling the link several times shows the blank character is produced only on the first rise after reset.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] BLANK_CODE = 8'h20;
  typedef logic [BYTE_W-1:0] char_t;

  // legal size: nonzero power of two not above lane count
  function automatic logic size_legal(input int unsigned sz, input int unsigned lanes);
    return (sz != 0) && ((sz & (sz - 1)) == 0) && (sz <= lanes);
  endfunction
endpackage

// File: rtl/clb_wr_lanes.sv
module clb_wr_lanes #(
  parameter int unsigned LANES = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned SIZE_W = OFF_W + 1,
  localparam int unsigned DATA_W = LANES * clb_pkg::BYTE_W
) (
  input  logic              en_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  we_o,
  output logic [DATA_W-1:0] wbyte_o
);
  for (genvar p = 0; p < LANES; p++) begin : g_pos
    logic [OFF_W-1:0] lane;
    assign lane = OFF_W'(p) - offset_i; // wraps mod LANES
    assign we_o[p] = en_i && ({1'b0, lane} < size_i);
    assign wbyte_o[p*8 +: 8] = wdata_i[lane*8 +: 8];
  end
endmodule

// File: rtl/clb_rd_lanes.sv
module clb_rd_lanes #(
  parameter int unsigned LANES = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned SIZE_W = OFF_W + 1,
  localparam int unsigned DATA_W = LANES * clb_pkg::BYTE_W
) (
  input  logic              legal_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] line_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] pos;
    assign pos = offset_i + OFF_W'(i);
    assign rdata_o[i*8 +: 8] = (legal_i && (SIZE_W'(i) < size_i)) ? line_i[pos*8 +: 8] : '0;
  end
endmodule

// File: rtl/clb_blank_once.sv
module clb_blank_once (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_i,
  output logic       blank_valid_o,
  output logic [7:0] blank_char_o
);
  logic done_q, blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      blank_q <= link_i && !done_q;
      if (link_i) done_q <= 1'b1;
    end
  end

  assign blank_valid_o = blank_q;
  assign blank_char_o  = clb_pkg::BLANK_CODE;

  // R9
  blank_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_valid_o |=> !blank_valid_o);
  // R9
  blank_needs_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_valid_o |-> $past(link_i));
endmodule

// File: rtl/char_line_buf.sv
module char_line_buf #(
  parameter int unsigned LANES = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned SIZE_W = OFF_W + 1,
  localparam int unsigned DATA_W = LANES * clb_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              link_up_i,
  output logic              blank_valid_o,
  output logic [7:0]        blank_char_o,
  output logic              refresh_o,
  output logic [DATA_W-1:0] line_o
);
  logic              fire, legal, wr_fire, rd_fire;
  logic [LANES-1:0]  we;
  logic [DATA_W-1:0] wbyte, rdata_d, rdata_q, line_q;
  logic              refresh_q, rsp_valid_q;

  assign req_ready_o = rst_ni;
  assign fire    = req_valid_i && req_ready_o;
  assign legal   = clb_pkg::size_legal(int'(req_size_i), LANES);
  assign wr_fire = fire && req_write_i && legal;
  assign rd_fire = fire && !req_write_i;

  clb_wr_lanes #(.LANES(LANES)) i_wr (
    .en_i(wr_fire), .offset_i(req_offset_i), .size_i(req_size_i),
    .wdata_i(req_wdata_i), .we_o(we), .wbyte_o(wbyte)
  );

  clb_rd_lanes #(.LANES(LANES)) i_rd (
    .legal_i(legal), .offset_i(req_offset_i), .size_i(req_size_i),
    .line_i(line_q), .rdata_o(rdata_d)
  );

  clb_blank_once i_blank (
    .clk_i(clk_i), .rst_ni(rst_ni), .link_i(link_up_i),
    .blank_valid_o(blank_valid_o), .blank_char_o(blank_char_o)
  );

  for (genvar p = 0; p < LANES; p++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    line_q[p*8 +: 8] <= '0;
      else if (we[p]) line_q[p*8 +: 8] <= wbyte[p*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refresh_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      refresh_q   <= wr_fire;
      rsp_valid_q <= rd_fire;
      if (rd_fire) rdata_q <= rdata_d;
    end
  end

  assign refresh_o   = refresh_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign line_o      = line_q;

  // R6
  refresh_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && legal) |=> refresh_o);
  // R6
  refresh_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> $past(req_valid_i && req_write_i));
  // R7
  bad_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !legal) |=> ($stable(line_o) && !refresh_o));
  // R4
  rsp_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  // R5
  read_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_size_i) == SIZE_W'(1)) |-> (rsp_rdata_o[DATA_W-1:8] == '0));
endmodule

// File: tb/test_char_line_buf.sv
`timescale 1ns/1ps
module test_char_line_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, link_up = 1'b0;
  logic [2:0]  req_offset = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, blank_valid, refresh;
  logic [63:0] rsp_rdata, line;
  logic [7:0]  blank_char;

  int checks = 0, fails = 0;
  bit chk_en = 1'b0;

  // behavioural model state
  byte unsigned mdl[8];
  bit          inited = 1'b0;
  bit          exp_refresh = 1'b0, exp_rsp = 1'b0, exp_blank = 1'b0;
  logic [63:0] exp_rdata = '0;

  always #4 clk = ~clk;

  char_line_buf i_char_line_buf (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_offset_i(req_offset), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .link_up_i(link_up), .blank_valid_o(blank_valid), .blank_char_o(blank_char),
    .refresh_o(refresh), .line_o(line)
  );

  function automatic logic [63:0] mdl_line();
    logic [63:0] v = '0;
    for (int p = 0; p < 8; p++) v[p*8 +: 8] = mdl[p];
    return v;
  endfunction

  function automatic bit legal(int s);
    return s == 1 || s == 2 || s == 4 || s == 8;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (chk_en) begin
    check(line == mdl_line(), "R3 line", line, mdl_line());
    check(refresh == exp_refresh, "R6 refresh", 64'(refresh), 64'(exp_refresh));
    check(rsp_valid == exp_rsp, "R4 rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
    if (exp_rsp) check(rsp_rdata == exp_rdata, "R4 R5 R8 rdata", rsp_rdata, exp_rdata);
    check(blank_valid == exp_blank, "R9 blank_valid", 64'(blank_valid), 64'(exp_blank));
    if (exp_blank) check(blank_char == 8'h20, "R9 blank_char", 64'(blank_char), 64'h20);
    check(req_ready == 1'b1, "R2 ready", 64'(req_ready), 64'h1);
  end

  // one clock: drive at negedge, update model just after the posedge
  task automatic cyc(input bit v, input bit w, input int off, input int sz,
                     input logic [63:0] d, input bit lk);
    @(negedge clk);
    req_valid = v; req_write = w; req_offset = 3'(off); req_size = 4'(sz);
    req_wdata = d; link_up = lk;
    @(posedge clk); #1;
    exp_refresh = v && w && legal(sz);
    exp_rsp = v && !w;
    exp_blank = lk && !inited;
    if (lk) inited = 1'b1;
    if (v && !w) begin
      exp_rdata = '0;
      if (legal(sz))
        for (int i = 0; i < sz; i++) exp_rdata[i*8 +: 8] = mdl[(off + i) % 8];
    end
    if (exp_refresh)
      for (int i = 0; i < sz; i++) mdl[(off + i) % 8] = d[i*8 +: 8];
  endtask

  task automatic wr(input int off, input int sz, input logic [63:0] d);
    cyc(1, 1, off, sz, d, link_up);
  endtask
  task automatic rd(input int off, input int sz);
    cyc(1, 0, off, sz, 64'h0, link_up);
  endtask
  task automatic idle(input bit lk);
    cyc(0, 0, 0, 0, 64'h0, lk);
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 8; p++) mdl[p] = 0;
    repeat (3) @(posedge clk);
    // R1: outputs quiet during reset
    #1 check(line == 0 && !refresh && !rsp_valid && !blank_valid, "R1 in reset",
             {line[59:0], refresh, rsp_valid, blank_valid, 1'b0}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_en = 1'b1;
    idle(0);
    // R3 R6: single bytes at every position
    for (int p = 0; p < 8; p++) wr(p, 1, 64'h41 + 64'(p));
    idle(0);
    // R4 R5: reads of every size and offset
    for (int s = 1; s <= 8; s = s * 2)
      for (int o = 0; o < 8; o++) rd(o, s);
    // R3: wrapping writes
    wr(6, 4, 64'h0000_0000_7a79_7877);
    rd(6, 4);
    wr(5, 8, 64'h3837_3635_3433_3231);
    rd(0, 8);
    rd(7, 2);
    wr(3, 2, 64'hffff_ffff_ffff_6261); // upper lanes must not land
    rd(2, 4);
    // R7: illegal write sizes
    wr(0, 0, 64'hdead_beef_dead_beef);
    wr(2, 3, 64'hdead_beef_dead_beef);
    wr(4, 7, 64'hdead_beef_dead_beef);
    wr(1, 15, 64'hdead_beef_dead_beef);
    idle(0);
    rd(0, 8);
    // R8: illegal read sizes
    rd(0, 3); rd(5, 0); rd(2, 15);
    // R6: back-to-back writes give continuous strobe, then drops
    wr(0, 2, 64'h5a5a); wr(2, 2, 64'h6b6b); idle(0); idle(0);
    // R9: link comes up, goes down, comes back
    idle(1); idle(1); idle(0); idle(1); idle(0); idle(1);
    wr(7, 1, 64'h21); rd(7, 1);
    idle(0);
    // R1: reset again clears line and re-arms blank
    @(negedge clk); rst_n = 1'b0; chk_en = 1'b0;
    #1 check(line == 0, "R1 async clear", line, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int p = 0; p < 8; p++) mdl[p] = 0;
    inited = 1'b0; exp_refresh = 0; exp_rsp = 0; exp_blank = 0;
    @(posedge clk); #1 chk_en = 1'b1;
    idle(1); idle(1); idle(0);
    rd(4, 8);
    idle(0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule